// File: doc/BRIEF.md
# Parallel-Port Bridge Register Sequencer

This block sits on the host side of a byte-wide parallel port and carries out single register transactions with an IDE bridge attached to that port. A request names a bank (task file or control), a register index, a direction, write data and one of three link modes. The sequencer then plays out a fixed series of port states. Each state is either a new value on the 8-bit data lines or a new value on the control lines. It samples the status inputs or the data input at set points in the series. For a read it rebuilds the register byte from the sampled fields.

The register address is never sent in the clear. It is combined by XOR with a key that depends on the mode and the direction, and the bridge decodes it on its side. Every port state is held for `HOLD` clock cycles, so the pacing can match slow cabling. One transaction runs at a time. When it ends, the block raises a one-cycle completion pulse, and at that moment the control lines have already gone back to their idle value.

Top module: `ppreg_seq`

## Requirements
- R1: After reset the control lines read 0x04, the data lines read 0x00 and are driven, `req_ready` is high and `rsp_done` is low.
- R2: The wire address is the index plus 0x80 when `req_bank` is 1 (control bank); it is the index alone when `req_bank` is 0.
- R3: A read with `req_mode`=0 (nibble) drives data = address^0x39, then control 0x01, control 0x03, data = address^0x39 again, samples status 1 as A, drives control 0x01, samples status 1 as B, then drives control 0x04.
- R4: The nibble read result has status-B bits 7:4 in its bits 7:4 and status-A bits 7:4 in its bits 3:0.
- R5: A read with `req_mode`=1 (5/3) drives data = address^0x31, control 0x01, data = (address^0x31)&0x37, control 0x03, control 0x05, data = (address^0x31)|0xF0, samples status 1 as A and status 2 as B, then drives control 0x04.
- R6: The 5/3 read result has status-2 bits 3:1 in its bits 7:5 and status-1 bits 7:3 in its bits 4:0.
- R7: A read with `req_mode`=2 (byte) drives data = address^0x29, control 0x01, 0x21, 0x23, samples the data input, then drives control 0x04. The result is the sampled byte. The data lines are driven exactly when control bit 5 is 0.
- R8: A write in any mode drives data = address^0x19, control 0x01, data = write value, control 0x03, control 0x04.
- R9: Each port state lasts exactly `HOLD` cycles, sample points included. `rsp_done` comes `steps*HOLD` cycles after the accepting edge (8 steps nibble read, 9 steps 5/3 read, 6 steps byte read, 5 steps write).
- R10: `req_ready` is low from the accepting edge until `rsp_done`. Requests presented while it is low have no effect on the ports or the result. `rsp_done` lasts one cycle, and the control lines read 0x04 whenever `req_ready` is high.
- R11: `req_mode`=3 behaves exactly as byte mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken on this edge |
| req_bank | input | 1 | 1 = control bank, 0 = task-file bank |
| req_index | input | IDX_W | Register index within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write value |
| req_mode | input | 2 | 0 nibble, 1 5/3, 2 or 3 byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Rebuilt read byte, valid with rsp_done |
| pp_data_out | output | 8 | Data lines towards the bridge |
| pp_data_oe | output | 1 | Data line driver enable |
| pp_ctl | output | 8 | Control lines |
| pp_data_in | input | 8 | Data lines from the bridge |
| pp_stat1 | input | 8 | Primary status lines |
| pp_stat2 | input | 8 | Secondary status lines |

## Verification
The bench attaches a bridge model that decodes the XORed address and answers with field layouts that put junk in the bits the sequencer must discard. A wrong key, a missing bank offset or a wrong mask would therefore show up as a wrong address or a wrong byte. Every port value is compared on every cycle against a per-step reference trace with a hold of three. A step played out of order, or a hold counted one short or one long, appears as a trace mismatch. A request held valid with different content while the block is busy tests that nothing latches mid-transaction. Writes followed by read-backs in each mode confirm that the write data reached the bridge at the control 0x03 strobe.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;

    typedef enum logic [1:0] {
        FL_NIB_RD  = 2'd0,
        FL_53_RD   = 2'd1,
        FL_BYTE_RD = 2'd2,
        FL_WRITE   = 2'd3
    } flavor_e;

    typedef enum logic [1:0] {
        OP_DATA   = 2'd0,
        OP_CTL    = 2'd1,
        OP_SAMP_A = 2'd2,
        OP_SAMP_B = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        DS_ENC   = 2'd0,
        DS_MASK  = 2'd1,
        DS_HIGH  = 2'd2,
        DS_WDATA = 2'd3
    } dsel_e;

    typedef enum logic [1:0] {
        SRC_ST1  = 2'd0,
        SRC_ST2  = 2'd1,
        SRC_DIN  = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    typedef struct packed {
        op_e        op;
        dsel_e      dsel;
        src_e       src;
        logic [7:0] ctl;
        logic       last;
    } step_t;

    localparam int          STEP_W   = 4;
    localparam logic [7:0]  CTL_IDLE = 8'h04;
    localparam logic [7:0]  BANK_OFS = 8'h80;
    localparam logic [7:0]  KEY_NIB  = 8'h39;
    localparam logic [7:0]  KEY_53   = 8'h31;
    localparam logic [7:0]  KEY_BYTE = 8'h29;
    localparam logic [7:0]  KEY_WR   = 8'h19;
    localparam logic [7:0]  MASK_53  = 8'h37;
    localparam logic [7:0]  HIGH_53  = 8'hF0;

    function automatic flavor_e pick_flavor(input logic [1:0] mode, input logic wr);
        if (wr)              return FL_WRITE;
        else if (mode == 2'd0) return FL_NIB_RD;
        else if (mode == 2'd1) return FL_53_RD;
        else                   return FL_BYTE_RD;
    endfunction

    function automatic logic [7:0] key_of(input flavor_e f);
        case (f)
            FL_NIB_RD: return KEY_NIB;
            FL_53_RD:  return KEY_53;
            FL_BYTE_RD: return KEY_BYTE;
            default:   return KEY_WR;
        endcase
    endfunction

endpackage

// File: rtl/ppreg_step_table.sv
module ppreg_step_table
    import ppreg_pkg::*;
(
    input  flavor_e           flavor,
    input  logic [STEP_W-1:0] idx,
    output step_t             step
);

    function automatic step_t mk_data(input dsel_e d);
        step_t s;
        s = '{op: OP_DATA, dsel: d, src: SRC_NONE, ctl: 8'h00, last: 1'b0};
        return s;
    endfunction

    function automatic step_t mk_ctl(input logic [7:0] v, input logic fin);
        step_t s;
        s = '{op: OP_CTL, dsel: DS_ENC, src: SRC_NONE, ctl: v, last: fin};
        return s;
    endfunction

    function automatic step_t mk_samp(input op_e o, input src_e s_src);
        step_t s;
        s = '{op: o, dsel: DS_ENC, src: s_src, ctl: 8'h00, last: 1'b0};
        return s;
    endfunction

    always_comb begin
        step = mk_ctl(CTL_IDLE, 1'b1);
        case (flavor)
            FL_NIB_RD: begin
                case (idx)
                    4'd0: step = mk_data(DS_ENC);
                    4'd1: step = mk_ctl(8'h01, 1'b0);
                    4'd2: step = mk_ctl(8'h03, 1'b0);
                    4'd3: step = mk_data(DS_ENC);
                    4'd4: step = mk_samp(OP_SAMP_A, SRC_ST1);
                    4'd5: step = mk_ctl(8'h01, 1'b0);
                    4'd6: step = mk_samp(OP_SAMP_B, SRC_ST1);
                    default: step = mk_ctl(CTL_IDLE, 1'b1);
                endcase
            end
            FL_53_RD: begin
                case (idx)
                    4'd0: step = mk_data(DS_ENC);
                    4'd1: step = mk_ctl(8'h01, 1'b0);
                    4'd2: step = mk_data(DS_MASK);
                    4'd3: step = mk_ctl(8'h03, 1'b0);
                    4'd4: step = mk_ctl(8'h05, 1'b0);
                    4'd5: step = mk_data(DS_HIGH);
                    4'd6: step = mk_samp(OP_SAMP_A, SRC_ST1);
                    4'd7: step = mk_samp(OP_SAMP_B, SRC_ST2);
                    default: step = mk_ctl(CTL_IDLE, 1'b1);
                endcase
            end
            FL_BYTE_RD: begin
                case (idx)
                    4'd0: step = mk_data(DS_ENC);
                    4'd1: step = mk_ctl(8'h01, 1'b0);
                    4'd2: step = mk_ctl(8'h21, 1'b0);
                    4'd3: step = mk_ctl(8'h23, 1'b0);
                    4'd4: step = mk_samp(OP_SAMP_A, SRC_DIN);
                    default: step = mk_ctl(CTL_IDLE, 1'b1);
                endcase
            end
            default: begin
                case (idx)
                    4'd0: step = mk_data(DS_ENC);
                    4'd1: step = mk_ctl(8'h01, 1'b0);
                    4'd2: step = mk_data(DS_WDATA);
                    4'd3: step = mk_ctl(8'h03, 1'b0);
                    default: step = mk_ctl(CTL_IDLE, 1'b1);
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ppreg_hold_timer.sv
module ppreg_hold_timer #(
    parameter int HOLD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);

    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

    generate
        if (HOLD <= 1) begin : g_single
            logic unused_tmr;
            assign unused_tmr = clk ^ rst_n ^ start ^ run;
            assign expire = 1'b1;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (start)
                    cnt_d = '0;
                else if (run && cnt_q != CNT_LAST)
                    cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign expire = (cnt_q == CNT_LAST);

            a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q <= CNT_LAST);
            a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
                start |=> cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/ppreg_byte_join.sv
module ppreg_byte_join
    import ppreg_pkg::*;
(
    input  flavor_e    flavor,
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] joined
);

    logic unused_b0;
    assign unused_b0 = b[0];

    always_comb begin
        case (flavor)
            FL_NIB_RD: joined = {b[7:4], a[7:4]};
            FL_53_RD:  joined = {b[3:1], a[7:3]};
            default:   joined = a;
        endcase
    end

endmodule

// File: rtl/ppreg_seq.sv
module ppreg_seq
    import ppreg_pkg::*;
#(
    parameter int IDX_W = 7,
    parameter int HOLD  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_bank,
    input  logic [IDX_W-1:0] req_index,
    input  logic             req_write,
    input  logic [7:0]       req_wdata,
    input  logic [1:0]       req_mode,
    output logic             rsp_done,
    output logic [7:0]       rsp_data,
    output logic [7:0]       pp_data_out,
    output logic             pp_data_oe,
    output logic [7:0]       pp_ctl,
    input  logic [7:0]       pp_data_in,
    input  logic [7:0]       pp_stat1,
    input  logic [7:0]       pp_stat2
);

    typedef struct packed {
        logic              busy;
        flavor_e           flavor;
        logic [STEP_W-1:0] step;
        logic [7:0]        enc;
        logic [7:0]        wdata;
        logic [7:0]        a;
        logic [7:0]        b;
        logic [7:0]        ctl;
        logic [7:0]        dout;
        logic              done;
        logic [7:0]        rdata;
        logic              entry;
    } state_t;

    state_t     s_d, s_q;
    step_t      cur_step, nxt_step;
    logic       tmr_start, tmr_expire;
    logic [7:0] joined;
    logic [7:0] req_addr;
    flavor_e    req_flavor;

    ppreg_step_table u_cur_tbl (
        .flavor (s_q.flavor),
        .idx    (s_q.step),
        .step   (cur_step)
    );

    ppreg_step_table u_nxt_tbl (
        .flavor (s_q.flavor),
        .idx    (STEP_W'(s_q.step + 1'b1)),
        .step   (nxt_step)
    );

    ppreg_hold_timer #(.HOLD(HOLD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (s_q.busy),
        .expire (tmr_expire)
    );

    ppreg_byte_join u_join (
        .flavor (s_q.flavor),
        .a      (s_q.a),
        .b      (s_q.b),
        .joined (joined)
    );

    function automatic state_t apply_step(input state_t s, input step_t st,
                                          input logic [7:0] din,
                                          input logic [7:0] st1,
                                          input logic [7:0] st2);
        state_t     r;
        logic [7:0] src_v;
        r = s;
        case (st.src)
            SRC_ST1: src_v = st1;
            SRC_ST2: src_v = st2;
            SRC_DIN: src_v = din;
            default: src_v = 8'h00;
        endcase
        case (st.op)
            OP_DATA: begin
                case (st.dsel)
                    DS_ENC:  r.dout = s.enc;
                    DS_MASK: r.dout = s.enc & MASK_53;
                    DS_HIGH: r.dout = s.enc | HIGH_53;
                    default: r.dout = s.wdata;
                endcase
            end
            OP_CTL:    r.ctl = st.ctl;
            OP_SAMP_A: r.a   = src_v;
            default:   r.b   = src_v;
        endcase
        return r;
    endfunction

    always_comb begin
        req_addr   = 8'(req_index) + (req_bank ? BANK_OFS : 8'h00);
        req_flavor = pick_flavor(req_mode, req_write);
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.entry  = 1'b0;
        tmr_start  = 1'b0;
        if (!s_q.busy) begin
            if (req_valid) begin
                s_d.busy   = 1'b1;
                s_d.flavor = req_flavor;
                s_d.step   = '0;
                s_d.enc    = req_addr ^ key_of(req_flavor);
                s_d.wdata  = req_wdata;
                s_d.dout   = req_addr ^ key_of(req_flavor);
                s_d.entry  = 1'b1;
                tmr_start  = 1'b1;
            end
        end else if (tmr_expire) begin
            if (cur_step.last) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.rdata = joined;
            end else begin
                s_d       = apply_step(s_q, nxt_step, pp_data_in, pp_stat1, pp_stat2);
                s_d.step  = STEP_W'(s_q.step + 1'b1);
                s_d.done  = 1'b0;
                s_d.entry = 1'b1;
                tmr_start = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.ctl <= CTL_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready   = !s_q.busy;
    assign rsp_done    = s_q.done;
    assign rsp_data    = s_q.rdata;
    assign pp_ctl      = s_q.ctl;
    assign pp_data_out = s_q.dout;
    assign pp_data_oe  = !s_q.ctl[5];

    a_r10_idle_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> pp_ctl == CTL_IDLE);
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r10_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !s_q.entry) |-> ($stable(pp_ctl) && $stable(pp_data_out)));
    a_r8_write_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.flavor == FL_WRITE) |-> pp_data_oe);

endmodule

// File: tb/ppreg_seq_bench.sv
module ppreg_seq_bench;

    localparam int IDX_W = 7;
    localparam int HOLD  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_bank = 1'b0;
    logic [IDX_W-1:0] req_index = '0;
    logic             req_write = 1'b0;
    logic [7:0]       req_wdata = 8'h00;
    logic [1:0]       req_mode = 2'd0;
    logic             rsp_done;
    logic [7:0]       rsp_data;
    logic [7:0]       pp_data_out;
    logic             pp_data_oe;
    logic [7:0]       pp_ctl;
    logic [7:0]       pp_data_in;
    logic [7:0]       pp_stat1;
    logic [7:0]       pp_stat2;

    always #2 clk = ~clk;

    ppreg_seq #(.IDX_W(IDX_W), .HOLD(HOLD)) u_ppreg_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_index(req_index),
        .req_write(req_write), .req_wdata(req_wdata), .req_mode(req_mode),
        .rsp_done(rsp_done), .rsp_data(rsp_data),
        .pp_data_out(pp_data_out), .pp_data_oe(pp_data_oe), .pp_ctl(pp_ctl),
        .pp_data_in(pp_data_in), .pp_stat1(pp_stat1), .pp_stat2(pp_stat2)
    );

    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // bridge model
    logic [7:0] dev_mem [256];
    logic [7:0] shadow  [256];
    logic [7:0] dev_addr = 8'h00;
    logic [7:0] dev_key = 8'h00;
    int         dev_mode = 0;
    bit         dev_wr = 1'b0;
    int         dev_exp_addr = 0;
    string      dev_tag = "R2";
    logic [7:0] prev_ctl = 8'h04;
    logic [7:0] val;

    always_comb begin
        val = dev_mem[dev_addr];
        if (dev_mode == 0)
            pp_stat1 = (pp_ctl == 8'h03) ? {val[3:0], 4'h9} : {val[7:4], 4'h6};
        else if (dev_mode == 1)
            pp_stat1 = {val[4:0], 3'b010};
        else
            pp_stat1 = 8'hC3;
        pp_stat2   = (dev_mode == 1) ? {4'hA, val[7:5], 1'b1} : 8'h3C;
        pp_data_in = (pp_ctl == 8'h23) ? val : 8'h5A;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ctl == 8'h04 && pp_ctl == 8'h01) begin
                dev_addr = pp_data_out ^ dev_key;
                check(int'(dev_addr) == dev_exp_addr, dev_tag, "decoded address",
                      int'(dev_addr), dev_exp_addr);
            end
            if (dev_wr && prev_ctl == 8'h01 && pp_ctl == 8'h03)
                dev_mem[dev_addr] = pp_data_out;
        end
        prev_ctl = pp_ctl;
    end

    // reference trace
    int   exp_ctl[$];
    int   exp_dat[$];
    int   cur_ctl;
    int   cur_dat;
    int   last_dat = 0;

    task automatic hold_push();
        for (int h = 0; h < HOLD; h++) begin
            exp_ctl.push_back(cur_ctl);
            exp_dat.push_back(cur_dat);
        end
    endtask

    task automatic sd(input int v); cur_dat = v & 255; hold_push(); endtask
    task automatic sc(input int v); cur_ctl = v; hold_push(); endtask
    task automatic ss(); hold_push(); endtask

    task automatic run_txn(input int mode, input bit bank, input int idx,
                           input bit wr, input int wdata, input string tag,
                           input bit hold_valid);
        int addr, key, enc, n, expv;
        bit trace_ok, ready_ok, oe_ok;
        int bad_c, bad_ec;
        addr = idx + (bank ? 128 : 0);
        key  = wr ? 'h19 : (mode == 0 ? 'h39 : (mode == 1 ? 'h31 : 'h29));
        enc  = addr ^ key;
        exp_ctl.delete();
        exp_dat.delete();
        cur_ctl = 4;
        cur_dat = last_dat;
        if (wr) begin
            sd(enc); sc(1); sd(wdata); sc(3); sc(4);             // R8
        end else if (mode == 0) begin
            sd(enc); sc(1); sc(3); sd(enc); ss(); sc(1); ss(); sc(4);   // R3
        end else if (mode == 1) begin
            sd(enc); sc(1); sd(enc & 'h37); sc(3); sc(5); sd(enc | 'hF0);
            ss(); ss(); sc(4);                                   // R5
        end else begin
            sd(enc); sc(1); sc('h21); sc('h23); ss(); sc(4);     // R7, R11
        end
        n = exp_ctl.size();
        dev_key = key[7:0];
        dev_mode = mode;
        dev_wr = wr;
        dev_exp_addr = addr;
        dev_tag = bank ? "R2" : tag;

        @(negedge clk);
        req_valid = 1'b1; req_bank = bank; req_index = IDX_W'(idx);
        req_write = wr; req_wdata = wdata[7:0]; req_mode = mode[1:0];
        @(posedge clk);
        trace_ok = 1; ready_ok = 1; oe_ok = 1; bad_c = 0; bad_ec = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (c == 0) begin
                if (hold_valid) begin
                    req_write = ~wr; req_wdata = 8'hEE;
                    req_index = IDX_W'(idx ^ 5); req_mode = 2'd1;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (int'(pp_ctl) != exp_ctl[c] || int'(pp_data_out) != exp_dat[c]) begin
                if (trace_ok) begin bad_c = int'({pp_ctl, pp_data_out}); bad_ec = (exp_ctl[c] << 8) | exp_dat[c]; end
                trace_ok = 0;
            end
            if (req_ready || rsp_done) ready_ok = 0;
            if (pp_data_oe != !exp_ctl[c][5]) oe_ok = 0;
        end
        check(trace_ok, tag, "port trace {ctl,data}", bad_c, bad_ec);
        check(trace_ok, "R9", "per-step hold", bad_c, bad_ec);
        check(ready_ok, "R10", "ready low / no done while busy", 0, 1);
        check(oe_ok, "R7", "data enable follows ctl bit5", 0, 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_done == 1'b1, "R9", "done after steps*HOLD", int'(rsp_done), 1);
        check(req_ready == 1'b1 && pp_ctl == 8'h04, "R10", "idle with ctl 4 at done",
              int'(pp_ctl), 4);
        if (!wr) begin
            expv = int'(shadow[addr]);
            check(int'(rsp_data) == expv, tag, "read byte", int'(rsp_data), expv);
        end else begin
            shadow[addr] = wdata[7:0];
        end
        @(negedge clk);
        check(rsp_done == 1'b0, "R10", "done one cycle", int'(rsp_done), 0);
        check(req_ready == 1'b1 && pp_ctl == 8'h04, "R10", "no request taken while busy",
              int'(pp_ctl), 4);
        last_dat = exp_dat[n-1];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dev_mem[i] = 8'((i * 37 + 11) & 255);
            shadow[i]  = 8'((i * 37 + 11) & 255);
        end
        repeat (3) @(negedge clk);
        check(pp_ctl == 8'h04, "R1", "reset ctl", int'(pp_ctl), 4);
        check(pp_data_out == 8'h00 && pp_data_oe, "R1", "reset data", int'(pp_data_out), 0);
        check(req_ready && !rsp_done, "R1", "reset ready/done",
              int'({req_ready, rsp_done}), 2);
        rst_n = 1'b1;
        @(negedge clk);

        run_txn(0, 0, 7,   0, 0,     "R3", 0);
        run_txn(0, 1, 6,   0, 0,     "R4", 0);
        run_txn(1, 0, 2,   0, 0,     "R5", 0);
        run_txn(1, 1, 3,   0, 0,     "R6", 0);
        run_txn(2, 0, 1,   0, 0,     "R7", 0);
        run_txn(2, 1, 127, 0, 0,     "R7", 1);
        run_txn(3, 0, 4,   0, 0,     "R11", 0);
        run_txn(0, 0, 7,   1, 'hA5,  "R8", 0);
        run_txn(0, 0, 7,   0, 0,     "R8", 0);
        run_txn(1, 1, 0,   1, 'h3C,  "R8", 1);
        run_txn(1, 1, 0,   0, 0,     "R6", 0);
        run_txn(2, 0, 100, 1, 'hFF,  "R8", 0);
        run_txn(3, 0, 100, 0, 0,     "R11", 0);
        run_txn(0, 1, 0,   0, 0,     "R2", 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule